// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block sequences a processor core between full power and three reduced-power
states: doze, nap and sleep. Software raises a global power-save bit and selects
a target state on a one-hot select bus. The controller then removes the enables
of the functional units, of bus snooping, of the time base and of the PLL. Each
state keeps its own set of resources alive. When an accepted wake event arrives,
the controller brings the core back to full power.

In full power, an optional dynamic gating mode clears the enable of every unit
that reports itself idle. This happens in the same cycle and needs no software
action. Doze and nap come back after a short resume interval of fixed length.
Sleep tells external logic that the PLL and the system clock may be stopped. On
wake from sleep, the controller turns the PLL back on and waits for lock before
it releases the units. Hard reset (`rst_n` low) is asynchronous and always
returns the block to full power.

Top module: `pmc_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, the block is in full power. Outputs in full power are: `unit_en` all ones (with `dyn_gate_en` low), `snoop_en`, `tbase_en` and `pll_en` high, and `sleep_ready` low.
- R2: In full power, `unit_en[i]` equals `!(dyn_gate_en && unit_idle[i])` in the same cycle, for each unit.
- R3: In full power, a request is `pwr_save_en` high with exactly one bit of `mode_sel` set (bit 0 doze, bit 1 nap, bit 2 sleep). If no wake event of the target state is pending, the target state's outputs appear in the cycle after the clock edge that samples the request.
- R4: In doze, `unit_en` is zero and `snoop_en`, `tbase_en` and `pll_en` are high. In nap, `unit_en` and `snoop_en` are zero and `tbase_en` and `pll_en` are high. `sleep_ready` is low in both.
- R5: In sleep, `unit_en`, `snoop_en`, `tbase_en` and `pll_en` are all low and `sleep_ready` is high.
- R6: Doze and nap wake on any of `wake_ext_irq`, `wake_smi`, `wake_dec`, `wake_soft_rst` or `wake_mchk`. Sleep wakes on the same set except `wake_dec`. A lone `wake_dec` leaves sleep unchanged.
- R7: After a wake from doze or nap, the block spends exactly `RESUME_CYC` (default 4) cycles with `unit_en` zero and `snoop_en`, `tbase_en` and `pll_en` high. Full power follows.
- R8: After a wake from sleep, `pll_en` is high and all other outputs are low until `pll_locked` is sampled high. Full power follows in the next cycle.
- R9: A request made while a wake event of the target state is already present is dropped, and the block stays in full power.
- R10: Driving `rst_n` low in any state restores full-power outputs at once, without waiting for a clock edge.
- R11: With `mode_sel` zero or with more than one bit set, or with `pwr_save_en` low, the block stays in full power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| pwr_save_en | input | 1 | Global power-save permission |
| mode_sel | input | 3 | One-hot target: bit 0 doze, bit 1 nap, bit 2 sleep |
| dyn_gate_en | input | 1 | Gate idle units while in full power |
| unit_idle | input | N_UNITS | Per-unit idle flags |
| wake_ext_irq | input | 1 | External interrupt |
| wake_smi | input | 1 | System management interrupt |
| wake_dec | input | 1 | Decrementer exception |
| wake_soft_rst | input | 1 | Soft reset request |
| wake_mchk | input | 1 | Machine check |
| pll_locked | input | 1 | PLL lock indication |
| unit_en | output | N_UNITS | Per-unit enables |
| snoop_en | output | 1 | Bus snoop logic enable |
| tbase_en | output | 1 | Time base / decrementer enable |
| pll_en | output | 1 | PLL enable |
| sleep_ready | output | 1 | External logic may stop PLL and clock |

## Verification
Outputs are decoded from one registered state. A request or wake sampled at edge k therefore shows up one cycle later, at edge k+1. The exceptions are the unit gating in full power, which follows `unit_idle` and `dyn_gate_en` in the same cycle, and hard reset, which acts without a clock. A resume from doze or nap holds the units off for `RESUME_CYC` edges after the wake edge. A resume from sleep holds them off until the edge after the one that samples lock. The bench keeps a behavioural model that advances on the same edges. Inputs change a quarter period after each rising edge, and the bench compares every output just after that, once per cycle. Directed checks at the state changes confirm the exact cycle of each transition.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_FULL   = 3'd0,
        PM_DOZE   = 3'd1,
        PM_NAP    = 3'd2,
        PM_SLEEP  = 3'd3,
        PM_RESUME = 3'd4,
        PM_RELOCK = 3'd5
    } pm_state_e;

    typedef struct packed {
        logic ext_irq;
        logic smi;
        logic dec;
        logic soft_rst;
        logic mchk;
    } wake_t;

    typedef struct packed {
        pm_state_e st;
    } pmc_regs_t;

    localparam int SEL_DOZE  = 0;
    localparam int SEL_NAP   = 1;
    localparam int SEL_SLEEP = 2;
    localparam int SEL_W     = 3;

endpackage

// File: rtl/pmc_wake_decode.sv
module pmc_wake_decode
    import pmc_pkg::*;
(
    input  wake_t ev,
    output logic  wake_light,
    output logic  wake_deep
);

    // Light states keep the time base alive, so the decrementer counts as a source.
    always_comb begin
        wake_deep  = ev.ext_irq | ev.smi | ev.soft_rst | ev.mchk;
        wake_light = wake_deep | ev.dec;
    end

endmodule

// File: rtl/pmc_resume_cnt.sv
module pmc_resume_cnt #(
    parameter int RESUME_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int CW = (RESUME_CYC < 2) ? 1 : $clog2(RESUME_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RESUME_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R7: once loaded, the count never stalls before reaching zero
    a_r7_cnt_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/pmc_unit_gate.sv
module pmc_unit_gate #(
    parameter int N_UNITS = 4
) (
    input  logic               full_on,
    input  logic               gate_en,
    input  logic [N_UNITS-1:0] idle,
    output logic [N_UNITS-1:0] en
);

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        assign en[i] = full_on & ~(gate_en & idle[i]);
    end

endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int N_UNITS    = 4,
    parameter int RESUME_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_save_en,
    input  logic [2:0]         mode_sel,
    input  logic               dyn_gate_en,
    input  logic [N_UNITS-1:0] unit_idle,
    input  logic               wake_ext_irq,
    input  logic               wake_smi,
    input  logic               wake_dec,
    input  logic               wake_soft_rst,
    input  logic               wake_mchk,
    input  logic               pll_locked,
    output logic [N_UNITS-1:0] unit_en,
    output logic               snoop_en,
    output logic               tbase_en,
    output logic               pll_en,
    output logic               sleep_ready
);

    pmc_regs_t r_d, r_q;
    wake_t     ev;
    logic      wake_light, wake_deep;
    logic      req_valid, pend;
    logic      cnt_load, cnt_done;
    logic      full_on;

    assign ev = '{ext_irq: wake_ext_irq, smi: wake_smi, dec: wake_dec,
                  soft_rst: wake_soft_rst, mchk: wake_mchk};

    pmc_wake_decode u_wake (
        .ev         (ev),
        .wake_light (wake_light),
        .wake_deep  (wake_deep)
    );

    pmc_resume_cnt #(.RESUME_CYC(RESUME_CYC)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .done  (cnt_done)
    );

    // Next-state logic
    always_comb begin
        r_d       = r_q;
        cnt_load  = 1'b0;
        req_valid = pwr_save_en && ($countones(mode_sel) == 1);
        pend      = mode_sel[SEL_SLEEP] ? wake_deep : wake_light;
        unique case (r_q.st)
            PM_FULL: begin
                if (req_valid && !pend) begin
                    if (mode_sel[SEL_SLEEP])    r_d.st = PM_SLEEP;
                    else if (mode_sel[SEL_NAP]) r_d.st = PM_NAP;
                    else                        r_d.st = PM_DOZE;
                end
            end
            PM_DOZE, PM_NAP: begin
                if (wake_light) begin
                    r_d.st   = PM_RESUME;
                    cnt_load = 1'b1;
                end
            end
            PM_SLEEP:  if (wake_deep)  r_d.st = PM_RELOCK;
            PM_RESUME: if (cnt_done)   r_d.st = PM_FULL;
            PM_RELOCK: if (pll_locked) r_d.st = PM_FULL;
            default:   r_d.st = PM_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '{st: PM_FULL};
        else
            r_q <= r_d;
    end

    // Resource enables decoded from the registered state
    always_comb begin
        full_on     = (r_q.st == PM_FULL);
        snoop_en    = 1'b0;
        tbase_en    = 1'b0;
        pll_en      = 1'b1;
        sleep_ready = 1'b0;
        unique case (r_q.st)
            PM_FULL, PM_DOZE, PM_RESUME: begin
                snoop_en = 1'b1;
                tbase_en = 1'b1;
            end
            PM_NAP:    tbase_en = 1'b1;
            PM_SLEEP: begin
                pll_en      = 1'b0;
                sleep_ready = 1'b1;
            end
            default: ;
        endcase
    end

    pmc_unit_gate #(.N_UNITS(N_UNITS)) u_gate (
        .full_on (full_on),
        .gate_en (dyn_gate_en),
        .idle    (unit_idle),
        .en      (unit_en)
    );

    // R6: any light wake leaves doze or nap for the resume interval
    a_r6_light_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == PM_DOZE || r_q.st == PM_NAP) && wake_light)
        |=> (r_q.st == PM_RESUME && unit_en == '0));

    // R6: a decrementer event alone leaves sleep unchanged
    a_r6_sleep_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ready && !wake_ext_irq && !wake_smi && !wake_soft_rst && !wake_mchk)
        |=> sleep_ready);

    // R7: the resume state ends only in full power
    a_r7_resume_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PM_RESUME) |=> (r_q.st == PM_RESUME || r_q.st == PM_FULL));

    // R8: units stay off until lock is seen
    a_r8_relock_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PM_RELOCK && !pll_locked) |=> (unit_en == '0 && pll_en));

    // R9: a request with a pending wake is dropped
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (full_on && req_valid && pend) |=> (r_q.st == PM_FULL));

    // R11: malformed or absent requests cause no entry
    a_r11_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (full_on && !req_valid) |=> (r_q.st == PM_FULL));

    // R5: sleep never coexists with a running PLL or time base
    a_r5_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ready |-> (!pll_en && !tbase_en && !snoop_en));

endmodule

// File: tb/pmc_top_bench.sv
module pmc_top_bench;

    localparam int CLK_PER = 10;
    localparam int N  = 4;
    localparam int RC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_save_en = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic dyn_gate_en = 1'b0;
    logic [N-1:0] unit_idle = '0;
    logic ext = 1'b0, smi = 1'b0, dec = 1'b0, srst = 1'b0, mchk = 1'b0;
    logic pll_locked = 1'b1;
    logic [N-1:0] unit_en;
    logic snoop_en, tbase_en, pll_en, sleep_ready;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    pmc_top #(.N_UNITS(N), .RESUME_CYC(RC)) u_pmc_top (
        .clk(clk), .rst_n(rst_n), .pwr_save_en(pwr_save_en), .mode_sel(mode_sel),
        .dyn_gate_en(dyn_gate_en), .unit_idle(unit_idle),
        .wake_ext_irq(ext), .wake_smi(smi), .wake_dec(dec),
        .wake_soft_rst(srst), .wake_mchk(mchk), .pll_locked(pll_locked),
        .unit_en(unit_en), .snoop_en(snoop_en), .tbase_en(tbase_en),
        .pll_en(pll_en), .sleep_ready(sleep_ready)
    );

    // Behavioural model: 0 full, 1 doze, 2 nap, 3 sleep, 4 resume, 5 relock
    int ms = 0;
    int rc = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms <= 0;
            rc <= 0;
        end else begin
            automatic bit wd = ext | smi | srst | mchk;
            automatic bit wl = wd | dec;
            case (ms)
                0: if (pwr_save_en && $countones(mode_sel) == 1) begin
                       if (mode_sel[2]) begin
                           if (!wd) ms <= 3;
                       end else if (!wl) begin
                           ms <= mode_sel[1] ? 2 : 1;
                       end
                   end
                1, 2: if (wl) begin ms <= 4; rc <= 1; end
                3: if (wd) ms <= 5;
                4: if (rc == RC) ms <= 0; else rc <= rc + 1;
                5: if (pll_locked) ms <= 0;
                default: ms <= 0;
            endcase
        end
    end

    function automatic logic [N+3:0] expect_out();
        logic [N-1:0] eu;
        eu = '0;
        case (ms)
            0: begin
                eu = dyn_gate_en ? ~unit_idle : '1;
                return {eu, 4'b1110};
            end
            1, 4: return {eu, 4'b1110};
            2: return {eu, 4'b0110};
            3: return {eu, 4'b0001};
            default: return {eu, 4'b0010};
        endcase
    endfunction

    function automatic string tag_of();
        case (ms)
            0: return "R2";
            1, 2: return "R4";
            3: return "R5";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic cmp_model();
        logic [N+3:0] got, exp;
        got = {unit_en, snoop_en, tbase_en, pll_en, sleep_ready};
        exp = expect_out();
        chk(got === exp, tag_of(), 32'(got), 32'(exp));
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #(CLK_PER/4);
            cmp_model();
        end
    endtask

    function automatic logic [N+3:0] outs();
        return {unit_en, snoop_en, tbase_en, pll_en, sleep_ready};
    endfunction

    localparam logic [N+3:0] FULL_O = {{N{1'b1}}, 4'b1110};

    initial begin
        #(CLK_PER/4);
        chk(outs() === FULL_O, "R1", 32'(outs()), 32'(FULL_O));
        cyc(2);
        rst_n = 1'b1;
        #1;
        chk(outs() === FULL_O, "R1", 32'(outs()), 32'(FULL_O));
        cyc(1);
        chk(outs() === FULL_O, "R1", 32'(outs()), 32'(FULL_O));

        // R2: dynamic gating of idle units
        dyn_gate_en = 1'b1; unit_idle = 4'b0101; #1;
        chk(unit_en === 4'b1010, "R2", 32'(unit_en), 32'h0a);
        unit_idle = 4'b1111; #1;
        chk(unit_en === 4'b0000, "R2", 32'(unit_en), 32'h0);
        dyn_gate_en = 1'b0; #1;
        chk(unit_en === 4'b1111, "R2", 32'(unit_en), 32'hf);
        unit_idle = '0;

        // R3/R4/R6/R7: doze entry, decrementer wake, resume interval
        pwr_save_en = 1'b1; mode_sel = 3'b001;
        cyc(1);
        chk(unit_en === '0 && snoop_en && pll_en, "R3", 32'(outs()), 32'h0e);
        pwr_save_en = 1'b0;
        cyc(2);
        dec = 1'b1;
        cyc(1);
        dec = 1'b0;
        chk(unit_en === '0 && snoop_en && tbase_en, "R6", 32'(outs()), 32'h0e);
        cyc(RC - 1);
        chk(unit_en === '0, "R7", 32'(unit_en), 32'h0);
        cyc(1);
        chk(outs() === FULL_O, "R7", 32'(outs()), 32'(FULL_O));

        // R4/R6: nap entry, machine check wake
        pwr_save_en = 1'b1; mode_sel = 3'b010;
        cyc(1);
        chk(!snoop_en && tbase_en && pll_en && unit_en === '0, "R4", 32'(outs()), 32'h06);
        pwr_save_en = 1'b0; mchk = 1'b1;
        cyc(1);
        mchk = 1'b0;
        cyc(RC);
        chk(outs() === FULL_O, "R7", 32'(outs()), 32'(FULL_O));

        // R6: soft reset wakes doze
        pwr_save_en = 1'b1; mode_sel = 3'b001;
        cyc(1);
        pwr_save_en = 1'b0; srst = 1'b1;
        cyc(1);
        srst = 1'b0;
        chk(unit_en === '0 && snoop_en, "R6", 32'(outs()), 32'h0e);
        cyc(RC);

        // R5/R6/R8: sleep entry with decrementer pending, ignored, then relock
        pwr_save_en = 1'b1; mode_sel = 3'b100; dec = 1'b1;
        cyc(1);
        chk(outs() === 8'h01, "R5", 32'(outs()), 32'h01);
        pwr_save_en = 1'b0;
        cyc(2);
        chk(sleep_ready === 1'b1, "R6", 32'(sleep_ready), 32'h1);
        dec = 1'b0; pll_locked = 1'b0; ext = 1'b1;
        cyc(1);
        ext = 1'b0;
        chk(outs() === 8'h02, "R8", 32'(outs()), 32'h02);
        cyc(2);
        chk(outs() === 8'h02, "R8", 32'(outs()), 32'h02);
        pll_locked = 1'b1;
        cyc(1);
        chk(outs() === FULL_O, "R8", 32'(outs()), 32'(FULL_O));

        // R9: pending wakes abort requests
        pwr_save_en = 1'b1; mode_sel = 3'b001; smi = 1'b1;
        cyc(1);
        chk(outs() === FULL_O, "R9", 32'(outs()), 32'(FULL_O));
        smi = 1'b0; mode_sel = 3'b100; srst = 1'b1;
        cyc(1);
        chk(outs() === FULL_O, "R9", 32'(outs()), 32'(FULL_O));
        srst = 1'b0;

        // R11: malformed selects
        mode_sel = 3'b011;
        cyc(1);
        chk(outs() === FULL_O, "R11", 32'(outs()), 32'(FULL_O));
        mode_sel = 3'b000;
        cyc(1);
        chk(outs() === FULL_O, "R11", 32'(outs()), 32'(FULL_O));
        pwr_save_en = 1'b0; mode_sel = 3'b010;
        cyc(1);
        chk(outs() === FULL_O, "R11", 32'(outs()), 32'(FULL_O));

        // R10: hard reset out of nap and out of sleep
        pwr_save_en = 1'b1;
        cyc(1);
        pwr_save_en = 1'b0;
        rst_n = 1'b0; #1;
        chk(outs() === FULL_O, "R10", 32'(outs()), 32'(FULL_O));
        cyc(1);
        rst_n = 1'b1;
        pwr_save_en = 1'b1; mode_sel = 3'b100;
        cyc(1);
        pwr_save_en = 1'b0;
        rst_n = 1'b0; #1;
        chk(outs() === FULL_O, "R10", 32'(outs()), 32'(FULL_O));
        cyc(1);
        rst_n = 1'b1;
        cyc(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PER * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule